// File: doc/BRIEF.md
# Keypad Wakeup Interrupt Detector

This block watches a small group of keypad lines and raises one interrupt request when their merged level goes from high to low. Each line has a direction bit. Only lines configured as inputs take part in the merge. The merge is a wired-AND: any enabled line held low pulls the merged level low. While that line stays low, presses on the other lines cannot produce a new falling edge.

The merged level is resynchronised and edge-detected on the system clock. A falling edge sets a sticky request flag, which software drops with a one-cycle clear strobe. A second copy of the merge is built straight from the raw pads and drives a wakeup output. That output works while the clock is stopped, so it can end a wait or stop state.

A global disable input cuts the pads off from both paths. While it is set, the merged level reads high, so no request and no wakeup can occur.

Top module: `key_wake_irq`

## Requirements
- R1: Direction bit value 0 makes a line an input that takes part in detection. Value 1 makes the line an output that is ignored: its pad level never affects the request or the wakeup.
- R2: When the AND of the enabled pads goes from 1 to 0, `irq_o` becomes 1. It is visible after the third rising clock edge following the pad change, because of two synchroniser stages and the flag register.
- R3: While any enabled line is held low, falling edges on the other enabled lines produce no new request.
- R4: While `key_dis_i` is 1, no request is set, whatever the pads and direction bits do.
- R5: While `key_dis_i` is 1, the pads present no value to the logic: the merged level reads high and `wake_o` stays 0.
- R6: Once set, `irq_o` stays 1 until a clear strobe arrives, even after the pads return high.
- R7: A one-cycle `flag_clr_i` pulse drops `irq_o` at the next clock edge. If a falling edge is detected in the same cycle as the clear, the flag stays 1.
- R8: `wake_o` is combinational from the raw pads. It is 1 exactly while the merged level of the enabled raw pads is 0 and the block is not disabled, and it needs no running clock.
- R9: After a synchronous reset with all enabled pads high, `irq_o` is 0 and no request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_pad_i | input | NUM_KEYS | Raw keypad pad levels |
| key_dir_i | input | NUM_KEYS | Per-line direction, 0 = input, 1 = output |
| key_dis_i | input | 1 | Global detection disable |
| flag_clr_i | input | 1 | One-cycle clear of the request flag |
| irq_o | output | 1 | Sticky interrupt request |
| wake_o | output | 1 | Combinational wakeup level |

## Verification
The bench sweeps every direction setting, both disable states and every pair of before and after pad vectors. Each step is compared against an arithmetic model of the wired-AND merge. A design that ORed the lines or edge-detected each line separately would fire when a second key falls while one is already held. A design that forgot the direction mask would react to output lines. Directed cases cover the following:
- A clear that lands in the very cycle of a new edge. A design that let the clear win would lose a key press.
- The flag holding after the keys are released. A design without a sticky flag would drop it.
- A pad change with the clock stopped. A design whose wakeup came from synchronised data would never wake.

// File: rtl/key_wake_pkg.sv
package key_wake_pkg;
  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } key_dir_e;
endpackage

// File: rtl/key_sync.sv
module key_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '1;
        else     stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '1;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/key_merge.sv
module key_merge
  import key_wake_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] pad_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             dis_i,
  output logic             level_o
);
  logic [WIDTH-1:0] masked;

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    assign masked[i] = pad_i[i] | (dir_i[i] == DIR_OUT);
  end

  assign level_o = dis_i | (&masked);
endmodule

// File: rtl/key_edge_flag.sv
module key_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic fall;

  assign fall = prev_q & ~level_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      flag_q <= fall | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(prev_q && !level_i)) |=> !flag_q);
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (prev_q && !level_i) |=> flag_q);
endmodule

// File: rtl/key_wake_irq.sv
module key_wake_irq #(
  parameter int unsigned NUM_KEYS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] key_pad_i,
  input  logic [NUM_KEYS-1:0] key_dir_i,
  input  logic                key_dis_i,
  input  logic                flag_clr_i,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_KEYS-1:0] pad_sync;
  logic                raw_level;
  logic                sync_level;

  key_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(key_pad_i), .q_o(pad_sync)
  );

  key_merge #(.WIDTH(NUM_KEYS)) u_merge_sync (
    .pad_i(pad_sync), .dir_i(key_dir_i), .dis_i(key_dis_i), .level_o(sync_level)
  );

  key_merge #(.WIDTH(NUM_KEYS)) u_merge_raw (
    .pad_i(key_pad_i), .dir_i(key_dir_i), .dis_i(key_dis_i), .level_o(raw_level)
  );

  key_edge_flag u_flag (
    .clk(clk), .rst(rst), .level_i(sync_level), .clr_i(flag_clr_i), .flag_o(irq_o)
  );

  assign wake_o = ~raw_level;

  assert_disable_no_req_R4: assert property (@(posedge clk) disable iff (rst)
    (key_dis_i && $past(key_dis_i)) |-> !$rose(irq_o));
  assert_disable_no_wake_R5: assert property (@(posedge clk) disable iff (rst)
    key_dis_i |-> !wake_o);
  assert_outputs_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (&key_dir_i) |-> !wake_o);
  assert_no_irq_after_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> !irq_o);
endmodule

// File: tb/key_wake_irq_tb.sv
module key_wake_irq_tb;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst = 1'b1;
  logic [3:0] pad = 4'hF;
  logic [3:0] dir = 4'h0;
  logic       dis = 1'b0;
  logic       clr = 1'b0;
  logic       irq;
  logic       wake;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 if (clk_run) clk = ~clk;

  key_wake_irq #(.NUM_KEYS(4), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .key_pad_i(pad), .key_dir_i(dir), .key_dis_i(dis),
    .flag_clr_i(clr), .irq_o(irq), .wake_o(wake)
  );

  function automatic logic merged(logic [3:0] p, logic [3:0] d, logic ds);
    return ds | (&(p | d));
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (pad=%h dir=%h dis=%b)", tag, act, exp, pad, dir, dis);
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(5);
    chk(irq, 1'b0, "R9 reset irq");
    chk(wake, 1'b0, "R9 reset wake");

    // R2 basic edge and R6 sticky
    pad = 4'hE; tick(2);
    chk(irq, 1'b0, "R2 not before third edge");
    tick(1);
    chk(irq, 1'b1, "R2 request on fall");
    pad = 4'hF; tick(5);
    chk(irq, 1'b1, "R6 sticky after release");
    clear_flag();
    chk(irq, 1'b0, "R7 clear drops flag");

    // R3 masking by held line
    pad = 4'hE; tick(4); clear_flag(); tick(1);
    pad = 4'hC; tick(4);
    chk(irq, 1'b0, "R3 held line masks other fall");
    pad = 4'hF; tick(4);

    // R7 collision: clear in the cycle of the edge
    pad = 4'h7; tick(2);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk(irq, 1'b1, "R7 edge wins over clear");
    clear_flag();
    chk(irq, 1'b0, "R7 later clear");
    pad = 4'hF; tick(4);

    // R4/R5 disable
    dis = 1'b1; tick(2);
    pad = 4'h0; #1;
    chk(wake, 1'b0, "R5 disabled no wake");
    tick(4);
    chk(irq, 1'b0, "R4 disabled no request");
    pad = 4'hF; tick(4); dis = 1'b0; tick(4);
    chk(irq, 1'b0, "R5 re-enable with pads high");

    // R8 wake with clock stopped
    @(negedge clk); clk_run = 1'b0; #20;
    pad = 4'hB; #1;
    chk(wake, 1'b1, "R8 wake without clock");
    pad = 4'hF; #1;
    chk(wake, 1'b0, "R8 wake release without clock");
    clk_run = 1'b1; tick(4); clear_flag();

    // exhaustive sweep R1..R5, R8
    for (int ds = 0; ds < 2; ds++) begin
      for (int d = 0; d < 16; d++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            dis = ds[0]; dir = 4'(d); pad = 4'(a);
            tick(4); clear_flag(); tick(1);
            chk(irq, 1'b0, "R7 flag idle before step");
            pad = 4'(b); #1;
            chk(wake, ~merged(4'(b), 4'(d), ds[0]), "R8 R1 R5 wake level");
            tick(3);
            chk(irq, merged(4'(a), 4'(d), ds[0]) & ~merged(4'(b), 4'(d), ds[0]),
                "R2 R1 R3 R4 request");
          end
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule